// File: doc/BRIEF.md
# Memory Bus Wait-State Timer

This block works out how many bus clock cycles a single memory access will take. Its inputs are the access address, a size flag (halfword or word), a sequential flag, and the programmable wait-control fields. The address is sorted into a timing class: fast internal regions, external work RAM, the 16-bit video-memory region, and four cartridge windows. Each class has its own cost rule. In the cartridge windows, the first-access cost and the sequential cost are chosen per window from the control fields.

A strobe samples the computed cost and loads it into a countdown. The ready output stays low while the access is in flight and rises for exactly one cycle when the access ends. The bus master uses that pulse to complete the transfer. The control fields only matter at the moment of the strobe. Changing them while an access is counting down does not affect that access.

Top module: `bus_wait_timer`

## Requirements
- R1: After reset, `ready_o` is 0 and `cycles_o` is 0 until the first strobe.
- R2: An access costs 1 cycle at any size in these ranges: below 0x0200_0000, 0x0300_0000 to 0x04FF_FFFF, 0x0700_0000 to 0x07FF_FFFF, and at or above 0x1000_0000.
- R3: In 0x0200_0000 to 0x02FF_FFFF, a halfword access costs 16 minus `xram_wait_i`, and a word access costs twice that. The largest value is 32.
- R4: In 0x0500_0000 to 0x06FF_FFFF, a halfword access costs 1 and a word access costs 2.
- R5: In cartridge space (address bit 27 set, below 0x1000_0000), the window is w = address bits [26:25]. The non-sequential cost comes from `first_wait_i[2w+1:2w]`, where code 0 gives 5, code 1 gives 4, code 2 gives 3 and code 3 gives 9.
- R6: For windows 0, 1 and 2, the sequential cost is 2 when `seq_wait_i[w]` is 1. When that bit is 0, the sequential cost is 3, 5 or 9 respectively.
- R7: For window 3, the sequential cost equals that window's non-sequential cost.
- R8: A cartridge access whose address bits [16:1] are all zero is charged as non-sequential, even when `seq_i` is 1.
- R9: A cartridge word access costs the base cost plus one extra sequential cost of its window. The base cost is the sequential cost if the access is sequential and the non-sequential cost otherwise.
- R10: After the clock edge that samples `valid_i`, `cycles_o` shows the cost N. `ready_o` stays 0 for N-1 cycles, then is 1 for exactly one cycle.
- R11: If the control inputs change after the strobe, the cost and ready timing of the access in flight stay the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Strobe that starts an access |
| addr_i | input | 32 | Access address |
| word_i | input | 1 | 1 = 32-bit word, 0 = 16-bit halfword |
| seq_i | input | 1 | 1 = sequential access |
| xram_wait_i | input | 4 | Work RAM wait field |
| first_wait_i | input | 8 | First-access code, 2 bits per cartridge window |
| seq_wait_i | input | 3 | Fast-sequential bit for windows 0 to 2 |
| ready_o | output | 1 | One-cycle pulse that ends the access |
| cycles_o | output | 6 | Cost of the most recent access |

## Verification
The bench covers the four first-access codes, because a swapped table entry shows up as a wrong count on only one code. It covers the three sequential defaults, which a shared default would merge into one value. It checks that the static RAM window follows its first-access cost. It places sequential accesses exactly on a 128 KB page boundary and one halfword past it; a design that lost the page rule would report the short sequential count at the boundary. It runs work RAM words at wait field 0, where an undersized counter would wrap 32 to 0. It also changes the control fields in mid-countdown, which a design that reads them combinationally would turn into an early or late ready pulse.

// File: rtl/bwt_pkg.sv
package bwt_pkg;
  typedef enum logic [1:0] {RG_FAST, RG_XRAM, RG_HALF, RG_CART} region_e;

  function automatic logic [3:0] first_cost(input logic [1:0] code);
    case (code)
      2'd0:    first_cost = 4'd5;
      2'd1:    first_cost = 4'd4;
      2'd2:    first_cost = 4'd3;
      default: first_cost = 4'd9;
    endcase
  endfunction

  function automatic logic [3:0] seq_default(input int win);
    case (win)
      0:       seq_default = 4'd3;
      1:       seq_default = 4'd5;
      default: seq_default = 4'd9;
    endcase
  endfunction
endpackage

// File: rtl/bwt_region_decode.sv
module bwt_region_decode
  import bwt_pkg::*;
#(
  parameter int N_WIN   = 4,
  parameter int WIN_LSB = 25,
  localparam int WIN_W  = $clog2(N_WIN)
) (
  input  logic [31:0]      addr_i,
  output region_e          region_o,
  output logic [WIN_W-1:0] win_o,
  output logic             page_zero_o
);
  logic [7:0] top_byte;
  logic       unused_bits;

  assign top_byte    = addr_i[31:24];
  assign win_o       = addr_i[WIN_LSB +: WIN_W];
  assign page_zero_o = (addr_i[16:1] == '0);
  assign unused_bits = ^{addr_i[23:17], addr_i[0]};

  always_comb begin
    if (addr_i[31:28] != 4'h0)       region_o = RG_FAST;
    else if (addr_i[27])             region_o = RG_CART;
    else if (top_byte == 8'h02)      region_o = RG_XRAM;
    else if (top_byte == 8'h05 || top_byte == 8'h06) region_o = RG_HALF;
    else                             region_o = RG_FAST;
  end
endmodule

// File: rtl/bwt_cost_calc.sv
module bwt_cost_calc
  import bwt_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int RAM_W  = 4,
  parameter int N_WIN  = 4,
  localparam int WIN_W = $clog2(N_WIN)
) (
  input  region_e            region_i,
  input  logic [WIN_W-1:0]   win_i,
  input  logic               page_zero_i,
  input  logic               word_i,
  input  logic               seq_i,
  input  logic [RAM_W-1:0]   xram_wait_i,
  input  logic [2*N_WIN-1:0] first_wait_i,
  input  logic [N_WIN-2:0]   seq_wait_i,
  output logic [CNT_W-1:0]   cost_o
);
  logic [3:0] n_win [N_WIN];
  logic [3:0] s_win [N_WIN];

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    assign n_win[w] = first_cost(first_wait_i[2*w +: 2]);
    if (w == N_WIN - 1) begin : g_sram
      assign s_win[w] = n_win[w];
    end else begin : g_rom
      assign s_win[w] = seq_wait_i[w] ? 4'd2 : seq_default(w);
    end
  end

  logic             seq_eff;
  logic [CNT_W-1:0] n_sel, s_sel, base, xcost;

  assign seq_eff = seq_i && !page_zero_i;
  assign n_sel   = CNT_W'(n_win[win_i]);
  assign s_sel   = CNT_W'(s_win[win_i]);
  assign base    = seq_eff ? s_sel : n_sel;
  assign xcost   = CNT_W'(2**RAM_W) - CNT_W'(xram_wait_i);

  always_comb begin
    case (region_i)
      RG_XRAM: cost_o = word_i ? (xcost << 1) : xcost;
      RG_HALF: cost_o = word_i ? CNT_W'(2) : CNT_W'(1);
      RG_CART: cost_o = base + (word_i ? s_sel : '0);
      default: cost_o = CNT_W'(1);
    endcase
  end
endmodule

// File: rtl/bwt_countdown.sv
module bwt_countdown #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cost_i,
  output logic             ready_o,
  output logic [CNT_W-1:0] cycles_o
);
  logic [CNT_W-1:0] cnt_q, cyc_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      cyc_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= cost_i;
      cyc_q  <= cost_i;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q <= CNT_W'(1)) busy_q <= 1'b0;
      else                    cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  assign ready_o  = busy_q && (cnt_q == CNT_W'(1));
  assign cycles_o = cyc_q;

  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !load_i) |=> !ready_o);
  a_r10_low_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && cost_i > CNT_W'(1)) |=> !ready_o);
  a_r11_hold_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(cycles_o));
endmodule

// File: rtl/bus_wait_timer.sv
module bus_wait_timer
  import bwt_pkg::*;
#(
  parameter int CNT_W   = 6,
  parameter int RAM_W   = 4,
  parameter int N_WIN   = 4,
  parameter int WIN_LSB = 25,
  localparam int WIN_W  = $clog2(N_WIN)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [31:0]        addr_i,
  input  logic               word_i,
  input  logic               seq_i,
  input  logic [RAM_W-1:0]   xram_wait_i,
  input  logic [2*N_WIN-1:0] first_wait_i,
  input  logic [N_WIN-2:0]   seq_wait_i,
  output logic               ready_o,
  output logic [CNT_W-1:0]   cycles_o
);
  region_e          region;
  logic [WIN_W-1:0] win;
  logic             page_zero;
  logic [CNT_W-1:0] cost;

  bwt_region_decode #(.N_WIN(N_WIN), .WIN_LSB(WIN_LSB)) u_dec (
    .addr_i     (addr_i),
    .region_o   (region),
    .win_o      (win),
    .page_zero_o(page_zero)
  );

  bwt_cost_calc #(.CNT_W(CNT_W), .RAM_W(RAM_W), .N_WIN(N_WIN)) u_cost (
    .region_i    (region),
    .win_i       (win),
    .page_zero_i (page_zero),
    .word_i      (word_i),
    .seq_i       (seq_i),
    .xram_wait_i (xram_wait_i),
    .first_wait_i(first_wait_i),
    .seq_wait_i  (seq_wait_i),
    .cost_o      (cost)
  );

  bwt_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (valid_i),
    .cost_i  (cost),
    .ready_o (ready_o),
    .cycles_o(cycles_o)
  );

  a_r2_cost_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> cost != '0);
  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> cost <= CNT_W'(2**(RAM_W+1)));
  a_r9_cart_word_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && region == RG_CART && word_i) |-> cost >= CNT_W'(4));
  a_r10_cycles_loaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> cycles_o == $past(cost));
endmodule

// File: tb/bus_wait_timer_tb_top.sv
module bus_wait_timer_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic        word_i = 1'b0;
  logic        seq_i = 1'b0;
  logic [3:0]  xram_wait_i = '0;
  logic [7:0]  first_wait_i = '0;
  logic [2:0]  seq_wait_i = '0;
  logic        ready_o;
  logic [5:0]  cycles_o;

  bus_wait_timer dut_i (.*);

  always #5 clk_i = ~clk_i;

  typedef struct {int cost; string tag;} item_t;
  item_t exp_q[$];
  int    n_chk = 0, n_bad = 0;
  bit    mon_active = 0;
  bit    chk_after = 0;

  function automatic int model(input logic [31:0] a, input bit w, input bit s,
                               input logic [3:0] xw, input logic [7:0] fw, input logic [2:0] sw);
    int nc, sc, win, base;
    int first_tab [4] = '{5, 4, 3, 9};
    int seq_tab [3] = '{3, 5, 9};
    if (a >= 32'h1000_0000) return 1;
    if (a[27]) begin
      win = int'(a[26:25]);
      nc = first_tab[fw[2*win +: 2]];
      if (win == 3) sc = nc;
      else sc = sw[win] ? 2 : seq_tab[win];
      base = (s && a[16:1] != 0) ? sc : nc;
      return w ? base + sc : base;
    end
    if (a[31:24] == 8'h02) return (16 - int'(xw)) * (w ? 2 : 1);
    if (a[31:24] == 8'h05 || a[31:24] == 8'h06) return w ? 2 : 1;
    return 1;
  endfunction

  task automatic issue(input logic [31:0] a, input bit w, input bit s, input logic [3:0] xw,
                       input logic [7:0] fw, input logic [2:0] sw, input string tag,
                       input bit disturb = 0);
    item_t it;
    @(negedge clk_i);
    addr_i = a; word_i = w; seq_i = s;
    xram_wait_i = xw; first_wait_i = fw; seq_wait_i = sw;
    valid_i = 1'b1;
    it.cost = model(a, w, s, xw, fw, sw);
    it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk_i);
    valid_i = 1'b0;
    if (disturb) begin
      @(negedge clk_i);
      xram_wait_i = ~xw; first_wait_i = ~fw; seq_wait_i = ~sw;
      addr_i = a ^ 32'h0200_0000; word_i = ~w; seq_i = ~s;
    end
    while (exp_q.size() != 0 || mon_active) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  // monitor: times each access from strobe to ready pulse
  initial begin
    item_t cur;
    int elapsed = 0;
    forever begin
      @(negedge clk_i);
      #1;
      if (chk_after) begin
        n_chk++;
        if (ready_o) begin
          n_bad++;
          $display("FAIL R10 %s: ready held, actual %0b expected 0", cur.tag, ready_o);
        end
        chk_after = 0;
      end
      if (mon_active) begin
        elapsed++;
        if (ready_o) begin
          n_chk++;
          if (elapsed != cur.cost || int'(cycles_o) != cur.cost) begin
            n_bad++;
            $display("FAIL %s: ready after %0d, cycles_o %0d, expected %0d",
                     cur.tag, elapsed, cycles_o, cur.cost);
          end
          mon_active = 0;
          chk_after = 1;
        end else if (elapsed > 40) begin
          n_chk++; n_bad++;
          $display("FAIL %s: no ready, actual %0d cycles expected %0d", cur.tag, elapsed, cur.cost);
          mon_active = 0;
        end
      end else if (ready_o && rst_ni) begin
        n_chk++; n_bad++;
        $display("FAIL R10: spurious ready, actual 1 expected 0");
      end
      if (!mon_active && exp_q.size() > 0) begin
        cur = exp_q.pop_front();
        mon_active = 1;
        elapsed = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    n_chk++;
    if (ready_o !== 1'b0 || cycles_o !== 6'd0) begin
      n_bad++;
      $display("FAIL R1: reset ready %0b cycles %0d, expected 0 0", ready_o, cycles_o);
    end
    // R2 fast regions
    issue(32'h0000_1000, 1, 0, 4'd3, 8'h00, 3'b000, "R2 low");
    issue(32'h1234_5678, 1, 1, 4'd3, 8'h00, 3'b000, "R2 unmapped");
    issue(32'h0300_0000, 1, 0, 4'd3, 8'h00, 3'b000, "R2 iram");
    issue(32'h0400_0010, 0, 0, 4'd3, 8'h00, 3'b000, "R2 io");
    issue(32'h0700_0000, 1, 0, 4'd3, 8'h00, 3'b000, "R2 oam");
    // R3 work RAM
    issue(32'h0200_0040, 0, 0, 4'd13, 8'h00, 3'b000, "R3 half");
    issue(32'h0200_0040, 1, 0, 4'd13, 8'h00, 3'b000, "R3 word");
    issue(32'h02FF_FFFC, 1, 1, 4'd0, 8'h00, 3'b000, "R3 max");
    // R4 16-bit video region
    issue(32'h0500_0000, 0, 0, 4'd0, 8'h00, 3'b000, "R4 half");
    issue(32'h0600_0004, 1, 0, 4'd0, 8'h00, 3'b000, "R4 word");
    // R5 first-access codes
    for (int c = 0; c < 4; c++)
      issue(32'h0800_0100, 0, 0, 4'd0, 8'(c), 3'b000, $sformatf("R5 code%0d", c));
    issue(32'h0A00_0100, 0, 0, 4'd0, 8'b0000_1100, 3'b000, "R5 win1");
    // R6 sequential defaults and fast bit
    issue(32'h0800_0100, 0, 1, 4'd0, 8'h00, 3'b000, "R6 win0 slow");
    issue(32'h0800_0100, 0, 1, 4'd0, 8'h00, 3'b001, "R6 win0 fast");
    issue(32'h0A00_0100, 0, 1, 4'd0, 8'h00, 3'b000, "R6 win1 slow");
    issue(32'h0C00_0100, 0, 1, 4'd0, 8'h00, 3'b000, "R6 win2 slow");
    issue(32'h0C00_0100, 0, 1, 4'd0, 8'h00, 3'b100, "R6 win2 fast");
    // R7 static RAM window
    issue(32'h0E00_0100, 0, 1, 4'd0, 8'b0100_0000, 3'b111, "R7 sram code1");
    issue(32'h0E00_0100, 0, 1, 4'd0, 8'b1100_0000, 3'b000, "R7 sram code3");
    // R8 page crossing
    issue(32'h0802_0000, 0, 1, 4'd0, 8'h03, 3'b001, "R8 boundary");
    issue(32'h0802_0001, 0, 1, 4'd0, 8'h03, 3'b001, "R8 boundary odd");
    issue(32'h0802_0002, 0, 1, 4'd0, 8'h03, 3'b001, "R8 past boundary");
    // R9 cartridge words
    issue(32'h0800_0100, 1, 0, 4'd0, 8'h03, 3'b000, "R9 nonseq word");
    issue(32'h0800_0100, 1, 1, 4'd0, 8'h03, 3'b001, "R9 seq word");
    issue(32'h0C00_0100, 1, 0, 4'd0, 8'h30, 3'b000, "R9 win2 word");
    issue(32'h0E00_0000, 1, 1, 4'd0, 8'h80, 3'b000, "R9 sram word");
    // R11 controls disturbed mid-access
    issue(32'h0200_0000, 1, 0, 4'd0, 8'h00, 3'b000, "R11 xram", 1);
    issue(32'h0C00_0100, 1, 0, 4'd0, 8'h30, 3'b000, "R11 cart", 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule